// File: doc/BRIEF.md
# LIN Bus Wake-up Detector

This block sits beside a LIN transceiver and listens to the bus while the node is parked in a low-power mode. The analog comparators are outside it: the bus level arrives as three digital flags (dominant, below the pre-wake low level, above the pre-wake high level). When the bus first drops below the pre-wake low level, the detector switches its receiver on and starts timing. A remote wake is recognised only when the bus stays dominant past a filter time and then rises again. The result is a single-cycle wake request.

A monitoring timer bounds how long the receiver may stay powered. If the bus floats at an intermediate level, the detector mutes itself with no wake. It then re-arms only after the bus has been seen high for a qualification time. If the bus is held dominant for the whole monitoring window, as with a short to ground, the receiver is also switched off. In that case the next release of the bus produces a wake directly.

In the quieter of the two low-power modes, a wake is honoured only while the transmit line is high. Dropping the low-power flag clears the detector at once. All three time windows are parameters counted in clock cycles.

Top module: `lin_wake_detector`

## Requirements
- R1: After reset, and in every cycle while `lp_on` is low, `rx_active` and `wake_req` are 0 whatever the bus flags do.
- R2: When the detector is armed and `lp_on` is high, a clock edge that samples `bus_prewake_lo`=1 raises `rx_active` in the following cycle.
- R3: A wake requires `bus_dom`=1 at FILT_CYC consecutive clock edges while the receiver is already active. The edge on which the receiver switches on does not count, so a dominant stretch that starts from a high bus must span FILT_CYC+1 edges.
- R4: Once the dominant stretch has qualified, the first edge that samples `bus_dom`=0 makes `wake_req` 1 for exactly one cycle, starting in the next cycle. `rx_active` falls in that same cycle.
- R5: If `bus_prewake_lo` returns to 0 before the dominant stretch qualifies, `rx_active` falls with no wake and the detector is armed again.
- R6: With `lp_silent`=1, a wake is issued only if `txd_hi`=1 at the edge that samples the release; otherwise the detector returns to armed with no wake. With `lp_silent`=0, `txd_hi` has no effect.
- R7: After one wake, no further wake is issued until `lp_on` has gone low and high again.
- R8: `rx_active` stays high for at most MON_CYC consecutive cycles. If the window ends while `bus_dom`=0, the receiver turns off with no wake and the detector is muted.
- R9: A muted detector ignores all dominant patterns. It re-arms only after `bus_prewake_hi`=1 at REARM_CYC consecutive edges.
- R10: If the monitoring window ends while `bus_dom`=1, `rx_active` falls. The next edge that samples `bus_dom`=0 then issues a wake, subject to R6.
- R11: An edge that samples `lp_on`=0 makes `rx_active` and `wake_req` 0 in the next cycle and leaves the detector armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lp_on | input | 1 | Node is in a low-power mode |
| lp_silent | input | 1 | 1: the low-power mode keeps the regulator on (TXD gating applies); 0: deepest mode |
| txd_hi | input | 1 | Level of the transmit line |
| bus_dom | input | 1 | Bus is below the dominant threshold |
| bus_prewake_lo | input | 1 | Bus is below the pre-wake low level |
| bus_prewake_hi | input | 1 | Bus is above the pre-wake high level |
| wake_req | output | 1 | One-cycle remote wake request |
| rx_active | output | 1 | Receiver power enable |

## Verification
The hardest case to reach is a bus stuck dominant through the whole monitoring window and then released. That release has to give a direct wake, while a float-level timeout must not. A second hard case is the muted detector, which must refuse a full dominant pattern until the bus has been high long enough. The bench shortens the three windows through parameters and drives directed stretches longer than the monitoring window, both at the dominant level and at the intermediate level. It then follows each with release patterns whose high phase is shorter or longer than the re-arm time. Random bus levels held for random lengths, with mode and TXD flips, are compared cycle by cycle against a bench model built from the requirements.

// File: rtl/lin_wk_pkg.sv
package lin_wk_pkg;

  typedef enum logic [2:0] {
    WK_IDLE   = 3'd0,  // armed, receiver off
    WK_LISTEN = 3'd1,  // receiver on, filtering dominant level
    WK_HELD   = 3'd2,  // dominant qualified, waiting for release
    WK_MUTED  = 3'd3,  // window expired on a floating bus
    WK_STUCK  = 3'd4,  // window expired on a dominant bus
    WK_DONE   = 3'd5   // wake issued, waiting for mode exit
  } wk_state_e;

  localparam int unsigned WK_NTMR   = 3;
  localparam int unsigned WK_T_FILT = 0;
  localparam int unsigned WK_T_MON  = 1;
  localparam int unsigned WK_T_ARM  = 2;

  function automatic logic wk_rx_on(input wk_state_e s);
    return (s == WK_LISTEN) || (s == WK_HELD);
  endfunction

endpackage

// File: rtl/lin_wk_rstsync.sv
module lin_wk_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = shift_q[LAST];

endmodule

// File: rtl/lin_wk_tmr.sv
module lin_wk_tmr #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);

  localparam int unsigned    CW   = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0]  LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (cnt_q != LAST) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign hit = run && (cnt_q == LAST);

endmodule

// File: rtl/lin_wk_fsm.sv
module lin_wk_fsm
  import lin_wk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lp_on,
  input  logic      lp_silent,
  input  logic      txd_hi,
  input  logic      bus_dom,
  input  logic      bus_lo,
  input  logic      flt_hit,
  input  logic      mon_hit,
  input  logic      arm_hit,
  output wk_state_e state_q,
  output logic      wake_q
);

  wk_state_e state_d;
  logic      wake_d;
  logic      gate_ok;

  assign gate_ok = !lp_silent || txd_hi;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    if (!lp_on) begin
      state_d = WK_IDLE;
    end else begin
      unique case (state_q)
        WK_IDLE: begin
          if (bus_lo) state_d = WK_LISTEN;
        end
        WK_LISTEN: begin
          if (!bus_lo) begin
            state_d = WK_IDLE;
          end else if (mon_hit) begin
            state_d = bus_dom ? WK_STUCK : WK_MUTED;
          end else if (flt_hit) begin
            state_d = WK_HELD;
          end
        end
        WK_HELD, WK_STUCK: begin
          if (!bus_dom) begin
            if (gate_ok) begin
              state_d = WK_DONE;
              wake_d  = 1'b1;
            end else begin
              state_d = WK_IDLE;
            end
          end else if (mon_hit && (state_q == WK_HELD)) begin
            state_d = WK_STUCK;
          end
        end
        WK_MUTED: begin
          if (arm_hit) state_d = WK_IDLE;
        end
        WK_DONE: begin
          state_d = WK_DONE;
        end
        default: state_d = WK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

endmodule

// File: rtl/lin_wake_detector.sv
module lin_wake_detector
  import lin_wk_pkg::*;
#(
  parameter int unsigned FILT_CYC  = 18000,
  parameter int unsigned MON_CYC   = 2000000,
  parameter int unsigned REARM_CYC = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_on,
  input  logic lp_silent,
  input  logic txd_hi,
  input  logic bus_dom,
  input  logic bus_prewake_lo,
  input  logic bus_prewake_hi,
  output logic wake_req,
  output logic rx_active
);

  localparam int unsigned TMR_LIM [WK_NTMR] = '{FILT_CYC, MON_CYC, REARM_CYC};

  logic               rst_core_n;
  wk_state_e          state;
  logic [WK_NTMR-1:0] tmr_run;
  logic [WK_NTMR-1:0] tmr_hit;

  lin_wk_rstsync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  assign tmr_run[WK_T_FILT] = (state == WK_LISTEN) && bus_dom;
  assign tmr_run[WK_T_MON]  = wk_rx_on(state);
  assign tmr_run[WK_T_ARM]  = (state == WK_MUTED) && bus_prewake_hi;

  generate
    for (genvar t = 0; t < WK_NTMR; t++) begin : g_tmr
      lin_wk_tmr #(.LIMIT(TMR_LIM[t])) u_tmr (
        .clk   (clk),
        .rst_n (rst_core_n),
        .run   (tmr_run[t]),
        .hit   (tmr_hit[t])
      );
    end
  endgenerate

  lin_wk_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .lp_on     (lp_on),
    .lp_silent (lp_silent),
    .txd_hi    (txd_hi),
    .bus_dom   (bus_dom),
    .bus_lo    (bus_prewake_lo),
    .flt_hit   (tmr_hit[WK_T_FILT]),
    .mon_hit   (tmr_hit[WK_T_MON]),
    .arm_hit   (tmr_hit[WK_T_ARM]),
    .state_q   (state),
    .wake_q    (wake_req)
  );

  assign rx_active = wk_rx_on(state);

endmodule

// File: rtl/lin_wk_chk.sv
module lin_wk_chk #(
  parameter int unsigned MON_CYC = 2000000
) (
  input logic clk,
  input logic rst_n,
  input logic lp_on,
  input logic lp_silent,
  input logic txd_hi,
  input logic bus_dom,
  input logic wake_req,
  input logic rx_active
);

  logic [31:0] rx_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_run <= '0;
    end else begin
      rx_run <= rx_active ? rx_run + 32'd1 : 32'd0;
    end
  end

  // R4: a wake request never lasts two cycles
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);

  // R4: a wake follows an edge that saw the bus released
  a_r4_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(!bus_dom));

  // R6: in the regulator-on mode a wake needs TXD high
  a_r6_silent_txd: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(!lp_silent || txd_hi));

  // R2: the receiver is only powered in a low-power mode
  a_r2_needs_lp: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |-> $past(lp_on));

  // R11: leaving low power clears both outputs
  a_r11_lp_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_on |=> (!rx_active && !wake_req));

  // R8: the receiver window is bounded
  a_r8_monitor_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_run <= MON_CYC);

endmodule

bind lin_wake_detector lin_wk_chk #(.MON_CYC(MON_CYC)) u_lin_wk_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lp_on     (lp_on),
  .lp_silent (lp_silent),
  .txd_hi    (txd_hi),
  .bus_dom   (bus_dom),
  .wake_req  (wake_req),
  .rx_active (rx_active)
);

// File: tb/lin_wake_detector_test.sv
`timescale 1ns/1ps
module lin_wake_detector_test;

  localparam int FILT  = 16;
  localparam int MON   = 120;
  localparam int REARM = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, lp_on, lp_silent, txd_hi, bus_dom, bus_lo, bus_hi;
  logic wake_req, rx_active;

  lin_wake_detector #(.FILT_CYC(FILT), .MON_CYC(MON), .REARM_CYC(REARM)) uut (
    .clk(clk), .rst_n(rst_n), .lp_on(lp_on), .lp_silent(lp_silent),
    .txd_hi(txd_hi), .bus_dom(bus_dom), .bus_prewake_lo(bus_lo),
    .bus_prewake_hi(bus_hi), .wake_req(wake_req), .rx_active(rx_active)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    wakes = 0;
  string cur_req = "R1";

  // bench model: 0 armed, 1 listen, 2 held, 3 muted, 4 stuck, 5 done
  int m_st, m_fc, m_mc, m_rc;
  bit m_wake;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_fc = 0; m_mc = 0; m_rc = 0; m_wake = 0;
  endtask

  task automatic model_step();
    bit fq, mx, rh, gate, nw;
    int nst;
    if (!rst_n) begin model_reset(); return; end
    fq   = (m_st == 1) && bus_dom && (m_fc == FILT-1);
    mx   = (m_st == 1 || m_st == 2) && (m_mc == MON-1);
    rh   = (m_st == 3) && bus_hi && (m_rc == REARM-1);
    gate = !lp_silent || txd_hi;
    nst  = m_st; nw = 0;
    if (!lp_on) nst = 0;
    else case (m_st)
      0: if (bus_lo) nst = 1;
      1: if (!bus_lo) nst = 0; else if (mx) nst = bus_dom ? 4 : 3; else if (fq) nst = 2;
      2, 4: if (!bus_dom) begin
              if (gate) begin nst = 5; nw = 1; end else nst = 0;
            end else if (mx && m_st == 2) nst = 4;
      3: if (rh) nst = 0;
      default: ;
    endcase
    m_fc = (m_st == 1 && bus_dom) ? ((m_fc == FILT-1) ? m_fc : m_fc + 1) : 0;
    m_mc = (m_st == 1 || m_st == 2) ? ((m_mc == MON-1) ? m_mc : m_mc + 1) : 0;
    m_rc = (m_st == 3 && bus_hi) ? ((m_rc == REARM-1) ? m_rc : m_rc + 1) : 0;
    m_st = nst; m_wake = nw;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    @(negedge clk);
    check(cur_req, "wake_req vs model", wake_req, m_wake);
    check(cur_req, "rx_active vs model", rx_active, (m_st == 1 || m_st == 2) ? 1 : 0);
    if (wake_req) wakes++;
  endtask

  // 0 high, 1 middle, 2 below pre-wake low, 3 dominant
  task automatic set_bus(input int lvl);
    bus_hi  = (lvl == 0);
    bus_lo  = (lvl >= 2);
    bus_dom = (lvl == 3);
  endtask

  task automatic hold(input int lvl, input int n, output int rx_cnt);
    rx_cnt = 0;
    set_bus(lvl);
    for (int i = 0; i < n; i++) begin
      tick();
      if (rx_active) rx_cnt++;
    end
  endtask

  task automatic pulse(input int n_dom, output int got, output int first_rel);
    int w0, d;
    w0 = wakes; first_rel = -1;
    hold(0, 4, d);
    hold(3, n_dom, d);
    set_bus(0);
    for (int i = 0; i < 6; i++) begin
      tick();
      if (wake_req && first_rel < 0) first_rel = i;
    end
    got = wakes - w0;
  endtask

  task automatic lp_cycle();
    lp_on = 1'b0; tick();
    lp_on = 1'b1; tick();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog expired: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int got, rel, rxc, w0, seg_lvl, seg_len;
    void'($urandom(32'd4711));
    rst_n = 1'b0; lp_on = 1'b0; lp_silent = 1'b0; txd_hi = 1'b0; set_bus(0);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state and inactivity outside low power
    cur_req = "R1";
    tick(); tick(); tick();
    check("R1", "rx_active after reset", rx_active, 0);
    check("R1", "wake_req after reset", wake_req, 0);
    w0 = wakes;
    hold(3, 40, rxc);
    check("R1", "rx cycles with lp_on low", rxc, 0);
    hold(0, 5, rxc);
    check("R1", "wakes with lp_on low", wakes - w0, 0);

    // R2: receiver switches on one cycle after the drop
    cur_req = "R2";
    lp_on = 1'b1;
    hold(0, 4, rxc);
    set_bus(3); tick();
    check("R2", "rx_active after drop", rx_active, 1);
    hold(0, 4, rxc);

    // R3 boundary and R5 abort
    cur_req = "R3";
    lp_cycle();
    pulse(FILT, got, rel);
    check("R3", "wakes for FILT dominant edges", got, 0);
    check("R5", "rx_active after short dominant", rx_active, 0);
    cur_req = "R5";
    pulse(FILT + 1, got, rel);
    check("R3", "wakes for FILT+1 dominant edges", got, 1);
    check("R4", "wake cycle after release", rel, 0);
    check("R4", "rx_active after wake", rx_active, 0);

    // R7: no second wake in the same low-power session
    cur_req = "R7";
    pulse(30, got, rel);
    check("R7", "second wake without mode exit", got, 0);

    // R6: TXD gating in the regulator-on mode
    cur_req = "R6";
    lp_cycle();
    lp_silent = 1'b1; txd_hi = 1'b0;
    pulse(30, got, rel);
    check("R6", "wake with silent and TXD low", got, 0);
    txd_hi = 1'b1;
    pulse(30, got, rel);
    check("R6", "wake with silent and TXD high", got, 1);
    lp_silent = 1'b0; txd_hi = 1'b0;

    // R8 floating bus, R9 re-arm rule
    cur_req = "R8";
    lp_cycle();
    hold(0, 4, rxc);
    hold(2, MON + 10, rxc);
    check("R8", "rx cycles on floating bus", rxc, MON);
    check("R8", "rx_active after window", rx_active, 0);
    cur_req = "R9";
    pulse(30, got, rel);
    check("R9", "wake while muted", got, 0);
    pulse(30, got, rel);
    check("R9", "wake after re-arm", got, 1);

    // R10 bus stuck dominant then released
    cur_req = "R10";
    lp_cycle();
    hold(0, 4, rxc);
    hold(3, MON + 20, rxc);
    check("R10", "rx cycles on stuck bus", rxc, MON);
    set_bus(0); tick();
    check("R10", "direct wake on release", wake_req, 1);
    hold(0, 5, rxc);

    // R11 exit low power while listening
    cur_req = "R11";
    lp_cycle();
    hold(0, 4, rxc);
    hold(3, 5, rxc);
    lp_on = 1'b0; tick();
    check("R11", "rx_active after lp_on drop", rx_active, 0);
    lp_on = 1'b1;
    w0 = wakes;
    hold(3, 3, rxc);
    hold(0, 6, rxc);
    check("R11", "wakes after short re-entry", wakes - w0, 0);

    // random phase against the model (R3, R8, R9, R10)
    cur_req = "R3,R8,R9,R10 random";
    for (int s = 0; s < 60; s++) begin
      seg_lvl = $urandom_range(0, 3);
      seg_len = ($urandom_range(0, 7) == 0) ? $urandom_range(MON - 5, MON + 40)
                                             : $urandom_range(1, 2 * FILT + 4);
      if ($urandom_range(0, 9) == 0) lp_on = ~lp_on;
      if ($urandom_range(0, 5) == 0) lp_silent = ~lp_silent;
      if ($urandom_range(0, 3) == 0) txd_hi = ~txd_hi;
      if (!lp_on && $urandom_range(0, 1) == 1) lp_on = 1'b1;
      hold(seg_lvl, seg_len, rxc);
    end

    summary();
    $finish;
  end

endmodule